// File: doc/BRIEF.md
# Three-level page table walker

This block turns a 39-bit virtual address into a 56-bit physical address. It walks a radix page table of three levels, each indexed by 9 bits of the virtual page number. A requester pulses `start` together with the virtual address, the kind of access (load, store or instruction fetch), the current privilege (user or supervisor), two permission-relaxing flags and the physical page number of the root table. The walker fetches one 8-byte table entry per level over a simple memory read port: it holds a request with its address until a response comes back. It ends with a one-cycle `done` pulse that carries either a translation or a fault code.

Leaves may sit at any level. A leaf above the bottom level maps a large page. The walker checks that such a page is aligned to its size, and it fills the low page-number bits from the virtual address. A global-mapping flag is gathered along the whole walk. Translation caching and hardware updates of the accessed and dirty bits are left to the surrounding logic.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req` and `done` are 0.
- R2: A `start` accepted while idle begins the walk at level 2. The first entry address is the root page number shifted left by 12, plus virtual address bits 38:30 times 8. `mem_req` and `mem_addr` stay unchanged until `mem_rsp_valid` is seen.
- R3: Entry layout: bit 0 valid, bit 1 readable, bit 2 writable, bit 3 executable, bit 4 user, bit 5 global, bits 53:10 page number. An entry with valid=0, or writable=1 with readable=0, ends the walk with fault code 1.
- R4: A valid entry with readable=0 and executable=0 points to the next table. Above level 0, the next fetch is from the entry page number shifted left by 12, plus the next 9-bit virtual index times 8, one level lower. At level 0 such an entry gives fault code 1.
- R5: A leaf fails with fault code 2 when the access is not allowed. A load needs readable, or executable when `exec_readable` is 1. A store needs writable. A fetch needs executable. In user mode the user bit must be 1. In supervisor mode a user page may be used only by loads and stores, and only when `sup_user_ok` is 1.
- R6: For a leaf at level L > 0, any of the low 9·L page-number bits that is set gives fault code 3. Otherwise the physical page number is the entry page number ORed with the low 9·L bits of the virtual page number.
- R7: On success `ok`=1 and `fault`=0. `paddr` is the physical page number followed by the 12-bit page offset. `leaf_entry` and `leaf_addr` give the leaf entry and its address, and `leaf_level` gives its level.
- R8: `global_map` is the OR of the global bits of every entry read during the walk.
- R9: A response with `mem_rsp_err`=1 ends the walk with fault code 4. A response that arrives while no request is pending is ignored.
- R10: `done` is a single-cycle pulse, after which the walker is idle again. `start` is ignored while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 39 | Virtual address to translate |
| access | input | 2 | 0 load, 1 store, 2 instruction fetch |
| user_mode | input | 1 | 1 user privilege, 0 supervisor |
| exec_readable | input | 1 | Loads may use execute-only pages |
| sup_user_ok | input | 1 | Supervisor may load/store user pages |
| root_ppn | input | 44 | Physical page number of the root table |
| mem_req | output | 1 | Entry read request, held until response |
| mem_addr | output | 56 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_err | input | 1 | Response carries an access error |
| mem_rsp_data | input | 64 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Walk produced a translation |
| fault | output | 3 | 0 none, 1 bad entry, 2 denied, 3 misaligned large page, 4 access error |
| paddr | output | 56 | Translated physical address |
| leaf_entry | output | 64 | Leaf entry that gave the translation |
| leaf_addr | output | 56 | Address of the leaf entry |
| leaf_level | output | 2 | Level of the leaf (0 = smallest page) |
| global_map | output | 1 | Global-mapping flag gathered along the walk |

## Verification
On every cycle, the assertions check these properties: a pending request holds its address, a descent always leads to another fetch, `done` never lasts two cycles, an access error always completes with code 4, a successful completion never carries a fault code, and an alignment fault is reported only above level 0. Other behaviour shows up only in the bench's scenarios, which compare results against a model memory. These cover the exact entry addresses and fetch counts, the permission outcomes under each privilege and flag combination, the merged large-page addresses, the global flag picked up from an intermediate pointer, and the fact that a repeated `start` or a stray response cannot disturb a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Entry flag bit positions (decoded by the checker and the walker)
  localparam int BIT_V   = 0;
  localparam int BIT_R   = 1;
  localparam int BIT_W   = 2;
  localparam int BIT_X   = 3;
  localparam int BIT_U   = 4;
  localparam int BIT_G   = 5;
  localparam int PPN_LSB = 10;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_BAD_ENTRY = 3'd1,
    FLT_DENIED    = 3'd2,
    FLT_MISALIGN  = 3'd3,
    FLT_BUS       = 3'd4
  } flt_e;

  typedef enum logic {
    WS_IDLE,
    WS_FETCH
  } wstate_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int LEVELS  = 3,
  parameter int IDX_W   = 9,
  parameter int LVL_W   = 2,
  parameter int PA_W    = 56,
  parameter int ENT_LOG = 3,
  localparam int VPN_W  = LEVELS * IDX_W
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  entry_addr
);

  // Select the 9-bit index belonging to the given level
  function automatic logic [IDX_W-1:0] level_index(input logic [VPN_W-1:0] v,
                                                   input logic [LVL_W-1:0] l);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (int'(l) == i) r = v[i*IDX_W +: IDX_W];
    end
    return r;
  endfunction

  logic [PA_W-1:0] byte_ofs;

  always_comb begin
    byte_ofs = '0;
    byte_ofs[ENT_LOG +: IDX_W] = level_index(vpn, level);
    entry_addr = base + byte_ofs;
  end

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic [4:0] flags,      // valid, readable, writable, executable, user
  input  logic [1:0] access,
  input  logic       user_mode,
  input  logic       exec_readable,
  input  logic       sup_user_ok,
  output logic       bad,
  output logic       pointer,
  output logic       allowed
);

  function automatic logic kind_ok(input logic [1:0] a, input logic r,
                                   input logic w, input logic x, input logic mx);
    case (acc_e'(a))
      ACC_LOAD:  return r | (mx & x);
      ACC_STORE: return w;
      ACC_FETCH: return x;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic priv_ok(input logic [1:0] a, input logic u_page,
                                   input logic usr, input logic sok);
    if (usr) return u_page;
    if (!u_page) return 1'b1;
    return sok && (acc_e'(a) != ACC_FETCH);
  endfunction

  always_comb begin
    bad     = !flags[BIT_V] || (flags[BIT_W] && !flags[BIT_R]);
    pointer = flags[BIT_V] && !flags[BIT_R] && !flags[BIT_X];
    allowed = kind_ok(access, flags[BIT_R], flags[BIT_W], flags[BIT_X], exec_readable)
              && priv_ok(access, flags[BIT_U], user_mode, sup_user_ok);
  end

endmodule

// File: rtl/ptw_leaf_merge.sv
module ptw_leaf_merge #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int LVL_W  = 2,
  parameter int PPN_W  = 44,
  parameter int OFS_W  = 12,
  localparam int VPN_W = LEVELS * IDX_W
) (
  input  logic [PPN_W-1:0]       ppn,
  input  logic [VPN_W-1:0]       vpn,
  input  logic [OFS_W-1:0]       pgofs,
  input  logic [LVL_W-1:0]       level,
  output logic                   misaligned,
  output logic [PPN_W+OFS_W-1:0] pa
);

  // Ones in the low 9*level bits of a page number
  function automatic logic [PPN_W-1:0] level_mask(input logic [LVL_W-1:0] l);
    logic [PPN_W-1:0] m;
    for (int b = 0; b < PPN_W; b++) m[b] = (b < int'(l) * IDX_W);
    return m;
  endfunction

  logic [PPN_W-1:0] mask;
  logic [PPN_W-1:0] vpn_ext;

  always_comb begin
    mask       = level_mask(level);
    vpn_ext    = {{(PPN_W-VPN_W){1'b0}}, vpn};
    misaligned = |(ppn & mask);
    pa         = {ppn | (vpn_ext & mask), pgofs};
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int OFS_W  = 12,
  parameter int PA_W   = 56,
  parameter int ENT_W  = 64,
  localparam int VPN_W   = LEVELS * IDX_W,
  localparam int VA_W    = VPN_W + OFS_W,
  localparam int PPN_W   = PA_W - OFS_W,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int ENT_LOG = $clog2(ENT_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [1:0]       access,
  input  logic             user_mode,
  input  logic             exec_readable,
  input  logic             sup_user_ok,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             busy,
  output logic             done,
  output logic             ok,
  output logic [2:0]       fault,
  output logic [PA_W-1:0]  paddr,
  output logic [ENT_W-1:0] leaf_entry,
  output logic [PA_W-1:0]  leaf_addr,
  output logic [LVL_W-1:0] leaf_level,
  output logic             global_map
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  // Walk state
  wstate_e          state_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] level_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q, mxr_q, sok_q;
  logic             g_acc_q;

  // Result registers
  logic             done_q, ok_q, glob_q;
  flt_e             fault_q;
  logic [PA_W-1:0]  pa_q, eaddr_q;
  logic [ENT_W-1:0] leaf_q;
  logic [LVL_W-1:0] lvl_q;

  // Named internal events
  logic             rsp_take, walk_descend, entry_bad, entry_ptr, entry_allowed;
  logic             leaf_misaligned, rsp_global;
  logic [PPN_W-1:0] entry_ppn;
  logic [PA_W-1:0]  merged_pa;
  flt_e             fault_next;

  assign entry_ppn  = mem_rsp_data[PPN_LSB +: PPN_W];
  assign rsp_global = mem_rsp_data[BIT_G];

  ptw_addr_gen #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W), .PA_W(PA_W), .ENT_LOG(ENT_LOG)
  ) u_addr (
    .base(base_q), .vpn(va_q[VA_W-1:OFS_W]), .level(level_q), .entry_addr(mem_addr)
  );

  ptw_entry_check u_check (
    .flags(mem_rsp_data[4:0]), .access(acc_q), .user_mode(user_q),
    .exec_readable(mxr_q), .sup_user_ok(sok_q),
    .bad(entry_bad), .pointer(entry_ptr), .allowed(entry_allowed)
  );

  ptw_leaf_merge #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W), .PPN_W(PPN_W), .OFS_W(OFS_W)
  ) u_merge (
    .ppn(entry_ppn), .vpn(va_q[VA_W-1:OFS_W]), .pgofs(va_q[OFS_W-1:0]),
    .level(level_q), .misaligned(leaf_misaligned), .pa(merged_pa)
  );

  assign rsp_take     = (state_q == WS_FETCH) && mem_rsp_valid;
  assign walk_descend = rsp_take && !mem_rsp_err && !entry_bad && entry_ptr
                        && (level_q != '0);

  always_comb begin
    if (mem_rsp_err)           fault_next = FLT_BUS;
    else if (entry_bad)        fault_next = FLT_BAD_ENTRY;
    else if (entry_ptr)        fault_next = FLT_BAD_ENTRY;  // pointer at the bottom level
    else if (!entry_allowed)   fault_next = FLT_DENIED;
    else if (leaf_misaligned)  fault_next = FLT_MISALIGN;
    else                       fault_next = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      base_q  <= '0;
      level_q <= '0;
      va_q    <= '0;
      acc_q   <= '0;
      user_q  <= 1'b0;
      mxr_q   <= 1'b0;
      sok_q   <= 1'b0;
      g_acc_q <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      glob_q  <= 1'b0;
      fault_q <= FLT_NONE;
      pa_q    <= '0;
      eaddr_q <= '0;
      leaf_q  <= '0;
      lvl_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        WS_IDLE: begin
          if (start) begin
            state_q <= WS_FETCH;
            base_q  <= {root_ppn, {OFS_W{1'b0}}};
            level_q <= TOP_LVL;
            va_q    <= vaddr;
            acc_q   <= access;
            user_q  <= user_mode;
            mxr_q   <= exec_readable;
            sok_q   <= sup_user_ok;
            g_acc_q <= 1'b0;
          end
        end
        WS_FETCH: begin
          if (walk_descend) begin
            base_q  <= {entry_ppn, {OFS_W{1'b0}}};
            level_q <= level_q - LVL_W'(1);
            g_acc_q <= g_acc_q | rsp_global;
          end else if (rsp_take) begin
            state_q <= WS_IDLE;
            done_q  <= 1'b1;
            ok_q    <= (fault_next == FLT_NONE);
            fault_q <= fault_next;
            pa_q    <= merged_pa;
            leaf_q  <= mem_rsp_data;
            eaddr_q <= mem_addr;
            lvl_q   <= level_q;
            glob_q  <= g_acc_q | rsp_global;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign mem_req    = (state_q == WS_FETCH);
  assign busy       = (state_q != WS_IDLE);
  assign done       = done_q;
  assign ok         = ok_q;
  assign fault      = fault_q;
  assign paddr      = pa_q;
  assign leaf_entry = leaf_q;
  assign leaf_addr  = eaddr_q;
  assign leaf_level = lvl_q;
  assign global_map = glob_q;

  // A pending read keeps its address until answered (R2)
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

  // A pointer above level 0 always leads to another fetch (R4)
  p_descend_refetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_descend |=> (mem_req && !done));

  // Alignment faults only come from large-page leaves (R6)
  p_misalign_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 3'(FLT_MISALIGN)) |-> (leaf_level != '0));

  // A successful completion never carries a fault code (R7)
  p_ok_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (fault == 3'(FLT_NONE)));

  // An access error on a pending read ends the walk with code 4 (R9)
  p_bus_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rsp_valid && mem_rsp_err) |=> (done && !ok && fault == 3'(FLT_BUS)));

  // Completion is a single-cycle pulse, leaving the walker idle (R10)
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;

  typedef struct packed {
    logic [38:0] va;
    logic [1:0]  acc;
    logic        usr;
    logic        mxr;
    logic        sok;
    logic [2:0]  flt;
    logic [55:0] pa;
    logic [1:0]  lvl;
    logic        glb;
    logic [55:0] ea;
    logic [2:0]  nf;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{ {9'd0,9'd0,9'd0,12'hABC},   2'd0,1'b0,1'b0,1'b0, 3'd0, 56'h12345ABC, 2'd0,1'b0, 56'h103000, 3'd3 },
    '{ {9'd0,9'd0,9'd0,12'h123},   2'd1,1'b0,1'b0,1'b0, 3'd0, 56'h12345123, 2'd0,1'b0, 56'h103000, 3'd3 },
    '{ {9'd0,9'd0,9'd0,12'h010},   2'd2,1'b0,1'b0,1'b0, 3'd2, 56'h0,        2'd0,1'b0, 56'h0,      3'd3 },
    '{ {9'd0,9'd0,9'd1,12'h005},   2'd2,1'b0,1'b0,1'b0, 3'd0, 56'h22005,    2'd0,1'b0, 56'h103008, 3'd3 },
    '{ {9'd0,9'd0,9'd1,12'h005},   2'd0,1'b0,1'b0,1'b0, 3'd2, 56'h0,        2'd0,1'b0, 56'h0,      3'd3 },
    '{ {9'd0,9'd0,9'd1,12'h005},   2'd0,1'b0,1'b1,1'b0, 3'd0, 56'h22005,    2'd0,1'b0, 56'h103008, 3'd3 },
    '{ {9'd0,9'd1,9'h1AB,12'h321}, 2'd0,1'b0,1'b0,1'b0, 3'd0, 56'h3AB321,   2'd1,1'b0, 56'h101008, 3'd2 },
    '{ {9'd0,9'd1,9'h1AB,12'h000}, 2'd1,1'b0,1'b0,1'b0, 3'd2, 56'h0,        2'd0,1'b0, 56'h0,      3'd2 },
    '{ {9'd1,9'h55,9'hAA,12'h777}, 2'd0,1'b0,1'b0,1'b0, 3'd0, 56'h4AAAA777, 2'd2,1'b0, 56'h100008, 3'd1 },
    '{ {9'd2,9'd0,9'd0,12'h000},   2'd0,1'b0,1'b0,1'b0, 3'd3, 56'h0,        2'd0,1'b0, 56'h0,      3'd1 },
    '{ {9'd3,9'd0,9'd0,12'h000},   2'd0,1'b0,1'b0,1'b0, 3'd1, 56'h0,        2'd0,1'b0, 56'h0,      3'd1 },
    '{ {9'd4,9'd0,9'd0,12'h000},   2'd0,1'b0,1'b0,1'b0, 3'd1, 56'h0,        2'd0,1'b0, 56'h0,      3'd1 },
    '{ {9'd0,9'd0,9'd2,12'h000},   2'd0,1'b0,1'b0,1'b0, 3'd1, 56'h0,        2'd0,1'b0, 56'h0,      3'd3 },
    '{ {9'd5,9'd0,9'd0,12'h044},   2'd0,1'b0,1'b0,1'b0, 3'd0, 56'h600044,   2'd1,1'b1, 56'h102000, 3'd2 },
    '{ {9'd6,9'd0,9'd0,12'h000},   2'd0,1'b0,1'b0,1'b0, 3'd4, 56'h0,        2'd0,1'b0, 56'h0,      3'd1 },
    '{ {9'd0,9'd2,9'd0,12'h008},   2'd0,1'b1,1'b0,1'b0, 3'd0, 56'h400008,   2'd1,1'b0, 56'h101010, 3'd2 },
    '{ {9'd0,9'd0,9'd0,12'h000},   2'd0,1'b1,1'b0,1'b0, 3'd2, 56'h0,        2'd0,1'b0, 56'h0,      3'd3 },
    '{ {9'd0,9'd2,9'd0,12'h008},   2'd0,1'b0,1'b0,1'b0, 3'd2, 56'h0,        2'd0,1'b0, 56'h0,      3'd2 },
    '{ {9'd0,9'd2,9'd0,12'h008},   2'd0,1'b0,1'b0,1'b1, 3'd0, 56'h400008,   2'd1,1'b0, 56'h101010, 3'd2 },
    '{ {9'd0,9'd2,9'd0,12'h008},   2'd2,1'b0,1'b0,1'b1, 3'd2, 56'h0,        2'd0,1'b0, 56'h0,      3'd2 }
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [38:0] vaddr = '0;
  logic [1:0]  access = '0;
  logic        user_mode = 1'b0, exec_readable = 1'b0, sup_user_ok = 1'b0;
  logic [43:0] root_ppn = 44'h100;
  logic        mem_req;
  logic [55:0] mem_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        busy, done, ok, global_map;
  logic [2:0]  fault;
  logic [55:0] paddr, leaf_addr;
  logic [63:0] leaf_entry;
  logic [1:0]  leaf_level;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .access(access),
    .user_mode(user_mode), .exec_readable(exec_readable), .sup_user_ok(sup_user_ok),
    .root_ppn(root_ppn), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .ok(ok), .fault(fault), .paddr(paddr),
    .leaf_entry(leaf_entry), .leaf_addr(leaf_addr), .leaf_level(leaf_level),
    .global_map(global_map)
  );

  function automatic logic [63:0] ent(input logic [43:0] ppn, input logic [9:0] fl);
    return (64'(ppn) << 10) | 64'(fl);
  endfunction

  // Model page tables: root at 0x100000
  function automatic logic [63:0] mem_word(input logic [55:0] a);
    case (a)
      56'h100000: return ent(44'h101,   10'h01);
      56'h100008: return ent(44'h40000, 10'hCF);
      56'h100010: return ent(44'h40001, 10'hCF);
      56'h100020: return ent(44'h5,     10'h05);
      56'h100028: return ent(44'h102,   10'h21);
      56'h101000: return ent(44'h103,   10'h01);
      56'h101008: return ent(44'h200,   10'hC3);
      56'h101010: return ent(44'h400,   10'hD7);
      56'h102000: return ent(44'h600,   10'hC7);
      56'h103000: return ent(44'h12345, 10'hC7);
      56'h103008: return ent(44'h22,    10'hC9);
      56'h103010: return ent(44'h7,     10'h01);
      default:    return 64'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R7";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int lat, input bit spam);
    int  nf;
    bit  fin;
    string tg;
    nf  = 0;
    fin = 1'b0;
    tg  = tag_of(v.flt);
    @(negedge clk);
    vaddr = v.va; access = v.acc; user_mode = v.usr;
    exec_readable = v.mxr; sup_user_ok = v.sok; start = 1'b1;
    @(negedge clk);
    if (spam) vaddr = 39'h7F_FFFF_FFFF;
    else start = 1'b0;
    for (int it = 0; it < 8 && !fin; it++) begin
      if (it == 0) chk("R2 first entry address", 64'(mem_addr), 64'(56'h100000 + 56'(v.va[38:30]) * 8));
      nf++;
      repeat (lat) @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_err   = (mem_addr == 56'h100030);
      mem_rsp_data  = mem_word(mem_addr);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (done) fin = 1'b1;
    end
    start = 1'b0;
    chk("R10 walk completed", 64'(fin), 64'd1);
    chk({tg, " fault code"}, 64'(fault), 64'(v.flt));
    chk({tg, " ok flag"}, 64'(ok), 64'(v.flt == 3'd0));
    chk("R4 fetch count", 64'(nf), 64'(v.nf));
    if (v.flt == 3'd0) begin
      chk("R7 paddr", 64'(paddr), 64'(v.pa));
      chk("R7 leaf level", 64'(leaf_level), 64'(v.lvl));
      chk("R7 leaf address", 64'(leaf_addr), 64'(v.ea));
      chk("R7 leaf entry", leaf_entry, mem_word(v.ea));
      chk("R8 global flag", 64'(global_map), 64'(v.glb));
    end
    @(negedge clk);
    chk("R10 done pulse ended", 64'(done), 64'd0);
    chk("R10 idle after walk", 64'(busy), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 mem_req", 64'(mem_req), 64'd0);
    chk("R1 done", 64'(done), 64'd0);

    // Vector table walk, latency 0..2 cycles
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3, 1'b0);

    // R9: stray response while idle is ignored
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_err = 1'b1; mem_rsp_data = '1;
    @(negedge clk);
    chk("R9 stray response busy", 64'(busy), 64'd0);
    chk("R9 stray response done", 64'(done), 64'd0);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    chk("R9 stray response done later", 64'(done), 64'd0);
    run_vec(VECS[0], 1, 1'b0);

    // R10: start held high with a changing address during a walk
    run_vec(VECS[6], 2, 1'b1);
    run_vec(VECS[13], 0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule